// File: doc/BRIEF.md
# Nested Software-Priority Interrupt Controller

This block decides which interrupt the core takes next. Fourteen request lines come in, and each maskable line has a two-bit software priority. The fields are packed four to a byte in four registers on a small register bus. The block keeps the current CPU level as the two mask bits of the condition code. Each cycle it grants the highest eligible request and reports the source and vector index to the core. On entry it raises the current level.

Request line 0 is the top-level interrupt. It is non-maskable, as are the trap and the hardware-reset event. These three are taken even at level 3, and each of them sets the current level to the disabled code. When a handler returns, the core pulses a strobe carrying the saved mask bits, and the block restores the current level from them. Vector fetch and stacking stay in the core.

Top module: `nested_prio_ctrl`

## Requirements
- R1: After synchronous reset every priority field is 11 and every register reads FFh. `cur_level` is 11 and `ack_valid` is low.
- R2: Register n holds vectors 4n to 4n+3. Vector 4n+k sits in bits [2k+1:2k], with the I1 bit above the I0 bit.
- R3: A written field equal to 10 leaves the stored field unchanged, and any other written value is stored. For example, writing 64h over CFh leaves 44h.
- R4: Bits 7:4 of register 3 always read as 1 and ignore writes.
- R5: Level codes rank in the order 10 < 01 < 00 < 11. A maskable request (lines 1 to 13) is taken only when its field ranks strictly above the current level, so equal or lower fields are held off.
- R6: A maskable request sampled at a clock edge is acknowledged at that edge with `ack_src` = 00 and `ack_vec` = its index. At the same edge `cur_level` is loaded with that vector's field.
- R7: Among the eligible requests, the highest rank wins, and a tie goes to the lowest index.
- R8: Line 0 is the top-level interrupt. It is taken at any level, including 11, and its field is ignored. It is reported as `ack_src` = 01, `ack_vec` = 0.
- R9: Precedence from highest to lowest is hardware reset event (`ack_src` 11), then top-level (01), then trap (10), then maskable. Each non-maskable grant reports vector 0 and sets `cur_level` to 11.
- R10: A return strobe loads `ret_level` into `cur_level`. Arbitration in that same cycle already compares against the restored level.
- R11: A priority write takes effect for arbitration one cycle later. If a running handler's request is still pending and its field is raised above the current level, the vector is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_pend | input | 14 | Pending requests; bit 0 is the top-level interrupt |
| trap_req | input | 1 | Trap request |
| hrst_req | input | 1 | Hardware-reset event request |
| ret_valid | input | 1 | Return strobe |
| ret_level | input | 2 | Saved mask bits restored on return |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_src | output | 2 | Granted source: 00 maskable, 01 top-level, 10 trap, 11 reset event |
| ack_vec | output | 4 | Granted vector index |
| cur_level | output | 2 | Current level mask bits |

## Verification
A return strobe and a new grant can land in the same cycle, and the order between them decides which request wins. The bench sets up this case with the current level at 11 and a level-2 request pending. It then pulses the return strobe with the main-level code in that same cycle. The check passes only if the request is acknowledged at that edge and `cur_level` ends at the vector's field rather than the restored bits. A priority write and a still-pending handler also meet in one cycle, and the bench checks that re-entry happens one edge later.

// File: rtl/nprio_pkg.sv
package nprio_pkg;
    localparam int NUM_VEC = 14;
    localparam int LVL_W   = 2;
    localparam int DATA_W  = 8;
    localparam int SLOTS   = DATA_W / LVL_W;
    localparam int REG_CNT = (NUM_VEC + SLOTS - 1) / SLOTS;
    localparam int ADDR_W  = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
    localparam int VEC_W   = $clog2(NUM_VEC);

    localparam logic [LVL_W-1:0] LVL_MAIN = 2'b10;
    localparam logic [LVL_W-1:0] LVL_DIS  = 2'b11;

    typedef enum logic [1:0] {
        SRC_MASK = 2'b00,
        SRC_TOP  = 2'b01,
        SRC_TRAP = 2'b10,
        SRC_HRST = 2'b11
    } src_e;

    typedef struct packed {
        logic             valid;
        src_e             src;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    // Map mask-bit code to numeric rank (0 lowest .. 3 highest).
    function automatic logic [1:0] lvl_rank(input logic [LVL_W-1:0] code);
        case (code)
            2'b10:   return 2'd0;
            2'b01:   return 2'd1;
            2'b00:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/nprio_regfile.sv
module nprio_regfile
    import nprio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_VEC*LVL_W-1:0] prio_flat
);
    localparam int LAST_USED = NUM_VEC - SLOTS * (REG_CNT - 1);
    localparam logic [DATA_W-1:0] RO_MASK =
        (LAST_USED >= SLOTS) ? '0 : (DATA_W'('1) << (LAST_USED * LVL_W));

    logic [LVL_W-1:0] fld [NUM_VEC];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_fld
        localparam int REG_IX = v / SLOTS;
        localparam int SLOT   = v % SLOTS;
        logic hit;
        logic [LVL_W-1:0] wf;
        assign hit = wr_en && (addr == ADDR_W'(REG_IX));
        assign wf  = wdata[LVL_W*SLOT +: LVL_W];

        always_ff @(posedge clk) begin
            if (rst)
                fld[v] <= LVL_DIS;
            else if (hit && wf != LVL_MAIN)
                fld[v] <= wf;
        end
        assign prio_flat[LVL_W*v +: LVL_W] = fld[v];

        assert_main_code_kept_R3: assert property (@(posedge clk) disable iff (rst)
            (hit && wf == LVL_MAIN) |=> $stable(fld[v]));
        assert_never_main_stored_R3: assert property (@(posedge clk) disable iff (rst)
            fld[v] != LVL_MAIN);
    end

    always_comb begin
        rdata = '1;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (addr == ADDR_W'(v / SLOTS))
                rdata[LVL_W*(v % SLOTS) +: LVL_W] = fld[v];
        end
    end

    assert_ro_bits_one_R4: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(REG_CNT - 1)) |-> ((rdata & RO_MASK) == RO_MASK));
endmodule

// File: rtl/nprio_arbiter.sv
module nprio_arbiter
    import nprio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_VEC*LVL_W-1:0] prio_flat,
    input  logic [NUM_VEC-1:0]       pend,
    input  logic [LVL_W-1:0]         level,
    input  logic                     trap_req,
    input  logic                     hrst_req,
    output grant_t                   gnt
);
    logic [1:0] cur_rank;
    logic [1:0] best_rank;
    logic       found;
    logic [LVL_W-1:0] p;

    always_comb begin
        cur_rank  = lvl_rank(level);
        best_rank = '0;
        found     = 1'b0;
        gnt       = '{valid: 1'b0, src: SRC_MASK, vec: '0, lvl: level};
        // Line 0 is non-maskable; its field is never consulted here.
        for (int i = 1; i < NUM_VEC; i++) begin
            p = prio_flat[LVL_W*i +: LVL_W];
            if (pend[i] && lvl_rank(p) > cur_rank &&
                (!found || lvl_rank(p) > best_rank)) begin
                found     = 1'b1;
                best_rank = lvl_rank(p);
                gnt       = '{valid: 1'b1, src: SRC_MASK, vec: VEC_W'(i), lvl: p};
            end
        end
        if (trap_req)
            gnt = '{valid: 1'b1, src: SRC_TRAP, vec: '0, lvl: LVL_DIS};
        if (pend[0])
            gnt = '{valid: 1'b1, src: SRC_TOP, vec: '0, lvl: LVL_DIS};
        if (hrst_req)
            gnt = '{valid: 1'b1, src: SRC_HRST, vec: '0, lvl: LVL_DIS};
    end

    assert_mask_strictly_higher_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt.valid && gnt.src == SRC_MASK) |-> (lvl_rank(gnt.lvl) > lvl_rank(level)));
    assert_mask_vec_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        (gnt.valid && gnt.src == SRC_MASK) |-> (gnt.vec != '0 && gnt.vec < VEC_W'(NUM_VEC)));
endmodule

// File: rtl/nested_prio_ctrl.sv
module nested_prio_ctrl
    import nprio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_VEC-1:0]   irq_pend,
    input  logic                 trap_req,
    input  logic                 hrst_req,
    input  logic                 ret_valid,
    input  logic [LVL_W-1:0]     ret_level,
    output logic                 ack_valid,
    output logic [1:0]           ack_src,
    output logic [VEC_W-1:0]     ack_vec,
    output logic [LVL_W-1:0]     cur_level
);
    logic [NUM_VEC*LVL_W-1:0] prio_flat;
    logic [LVL_W-1:0]         level_eff;
    grant_t                   gnt;

    nprio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .prio_flat (prio_flat)
    );

    // Return restores first, so arbitration sees the restored level.
    assign level_eff = ret_valid ? ret_level : cur_level;

    nprio_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .prio_flat (prio_flat),
        .pend      (irq_pend),
        .level     (level_eff),
        .trap_req  (trap_req),
        .hrst_req  (hrst_req),
        .gnt       (gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_level <= LVL_DIS;
            ack_valid <= 1'b0;
            ack_src   <= SRC_MASK;
            ack_vec   <= '0;
        end else begin
            ack_valid <= gnt.valid;
            ack_src   <= gnt.src;
            ack_vec   <= gnt.vec;
            cur_level <= gnt.valid ? gnt.lvl : level_eff;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_level == LVL_DIS && !ack_valid));
    assert_nonmask_disables_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src != SRC_MASK) |-> (cur_level == LVL_DIS && ack_vec == '0));
    assert_entry_raises_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src == SRC_MASK) |-> (lvl_rank(cur_level) > lvl_rank($past(level_eff))));
    assert_return_restores_R10: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !gnt.valid) |=> (cur_level == $past(ret_level)));
endmodule

// File: tb/nested_prio_ctrl_bench.sv
`timescale 1ns/1ps
module nested_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [13:0] irq_pend = '0;
    logic        trap_req = 1'b0;
    logic        hrst_req = 1'b0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_level = '0;
    logic        ack_valid;
    logic [1:0]  ack_src;
    logic [3:0]  ack_vec;
    logic [1:0]  cur_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    nested_prio_ctrl u_nested_prio_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
        .trap_req(trap_req), .hrst_req(hrst_req), .ret_valid(ret_valid),
        .ret_level(ret_level), .ack_valid(ack_valid), .ack_src(ack_src),
        .ack_vec(ack_vec), .cur_level(cur_level)
    );

    // Monitor: a quarter period after each edge, compare against queue head.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                logic [8:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {ack_valid, ack_src, ack_vec, cur_level};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s ack/src/vec/lvl actual %b_%b_%h_%b expected %b_%b_%h_%b",
                             t, a[8], a[7:6], a[5:2], a[1:0], e[8], e[7:6], e[5:2], e[1:0]);
                end
            end
        end
    end

    // Driver: set inputs for the next edge and push the expected outcome.
    task automatic step(input logic [13:0] p, input logic tr, input logic hr,
                        input logic rv, input logic [1:0] rl,
                        input logic wr, input logic [1:0] wa, input logic [7:0] wd,
                        input logic ev, input logic [1:0] es, input logic [3:0] evec,
                        input logic [1:0] el, input string tag);
        @(negedge clk);
        irq_pend = p; trap_req = tr; hrst_req = hr;
        ret_valid = rv; ret_level = rl;
        bus_wr = wr; bus_addr = wa; bus_wdata = wd;
        exp_q.push_back({ev, es, evec, el});
        tag_q.push_back(tag);
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        irq_pend = '0; trap_req = 0; hrst_req = 0; ret_valid = 0;
        bus_wr = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg%0d actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cur_level == 2'b11, "R1 reset level", {6'd0, cur_level}, 8'h03);
        chk(ack_valid == 1'b0, "R1 reset ack", {7'd0, ack_valid}, 8'h00);
        for (int a = 0; a < 4; a++) read_chk(2'(a), 8'hFF, "R1 reset read");

        // Register filtering and layout (R2 R3 R4)
        step(0,0,0,0,0, 1,2'd0,8'hCF, 0,0,0,2'b11, "R3 write idle");
        step(0,0,0,0,0, 1,2'd0,8'h64, 0,0,0,2'b11, "R3 write idle");
        read_chk(2'd0, 8'h44, "R3 filtered write");
        step(0,0,0,0,0, 1,2'd3,8'h00, 0,0,0,2'b11, "R4 write idle");
        read_chk(2'd3, 8'hF0, "R4 upper bits read one");
        step(0,0,0,0,0, 1,2'd3,8'h06, 0,0,0,2'b11, "R3 write idle");
        read_chk(2'd3, 8'hF4, "R3 field keep in reg3");
        step(0,0,0,0,0, 1,2'd1,8'h00, 0,0,0,2'b11, "R2 write idle");
        step(0,0,0,0,0, 1,2'd2,8'hFF, 0,0,0,2'b11, "R2 write idle");
        read_chk(2'd1, 8'h00, "R2 reg1 layout");
        read_chk(2'd2, 8'hFF, "R2 reg2 layout");
        // Fields now: v1=01 v2=00 v3=01 v4..7=00 v8..11=11 v12=00 v13=01

        step(0,0,0,1,2'b10, 0,0,0, 0,0,0,2'b10, "R10 return to main");
        step(14'h0008,0,0,0,0, 0,0,0, 1,2'b00,4'd3,2'b01, "R6 take v3");
        step(14'h0008,0,0,0,0, 0,0,0, 0,0,0,2'b01, "R5 equal held off");
        step(14'h000A,0,0,0,0, 0,0,0, 0,0,0,2'b01, "R5 equal v1 held off");
        step(14'h002A,0,0,0,0, 0,0,0, 1,2'b00,4'd5,2'b00, "R5 higher v5 nests");
        step(0,0,0,1,2'b10, 0,0,0, 0,0,0,2'b10, "R10 return to main");
        step(14'h20D2,0,0,0,0, 0,0,0, 1,2'b00,4'd4,2'b00, "R7 tie lowest index");
        step(14'h0010,0,0,0,0, 1,2'd1,8'h03, 0,0,0,2'b00, "R11 write not yet seen");
        step(14'h0010,0,0,0,0, 0,0,0, 1,2'b00,4'd4,2'b11, "R11 re-entry");
        step(14'h0010,0,0,0,0, 0,0,0, 0,0,0,2'b11, "R11 no repeat");
        step(14'h0001,0,0,0,0, 0,0,0, 1,2'b01,4'd0,2'b11, "R8 top-level at level 3");
        step(14'h0100,0,0,0,0, 0,0,0, 0,0,0,2'b11, "R5 level 3 blocks");
        step(14'h0101,1,1,1,2'b10, 0,0,0, 1,2'b11,4'd0,2'b11, "R9 reset event first");
        step(14'h0101,1,0,1,2'b10, 0,0,0, 1,2'b01,4'd0,2'b11, "R9 top over trap");
        step(14'h0100,1,0,1,2'b10, 0,0,0, 1,2'b10,4'd0,2'b11, "R9 trap over maskable");
        step(14'h0100,0,0,1,2'b10, 0,0,0, 1,2'b00,4'd8,2'b11, "R9 maskable last");
        step(14'h0020,0,0,1,2'b10, 0,0,0, 1,2'b00,4'd5,2'b00, "R10 return and grant");
        step(0,0,0,1,2'b01, 0,0,0, 0,0,0,2'b01, "R10 restore level 1");
        step(0,0,0,0,0, 0,0,0, 0,0,0,2'b01, "R10 level held");

        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule